// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio N = 32·M + S. It emits one divided pulse per N input cycles, which feeds a phase comparator. Inside, a dual-modulus prescaler divides by 33 or by 32. A 5-bit swallow count S sets how many prescaler cycles use the longer modulus. A 13-bit main count M sets how many prescaler cycles make up one output period. The prescaler is plain synchronous logic in the same clock domain as the counters.

A controller writes an 18-bit ratio word and strobes a load input. The word is held as a pending ratio. It moves into the counters only when the running period ends, so no period is ever cut short. A sleep input stops the prescaler and silences the output, but the block still accepts new ratio words while asleep. A reset input stops everything and restores the built-in ratio of 10372.

Top module: `swallow_div`

## Requirements
- R1: After reset is released, the divider runs with the built-in ratio M = 324, S = 4. The first pulse comes 10372 clock edges after release, and later pulses are spaced 10372 cycles apart.
- R2: For M in 32..8191 and S in 0..31, the spacing between consecutive output pulses is exactly 32·M + S input clock cycles.
- R3: Within each output period, the prescaler divides by 33 for the first S prescaler cycles and by 32 for the remaining M − S cycles. Its count never exceeds 32, and it reaches 32 only while the swallow count is non-zero.
- R4: Each output pulse is high for exactly one input clock cycle.
- R5: A ratio loaded in the middle of a period does not change that period. It takes effect from the next period onward.
- R6: When several loads happen within one period, the last one loaded is the one used in the next period.
- R7: A loaded main count below 32 is replaced by 32. For example, the word with M = 5, S = 3 gives a period of 1027.
- R8: While sleep is high, no pulse is produced and the prescaler count is held at zero. Loads made during sleep are kept. The first pulse after sleep is released comes exactly N edges later, where N uses the latest loaded ratio.
- R9: While reset is high, the output stays low and any load is ignored. After release, the built-in ratio 10372 applies again.
- R10: The ratio word bits [17:5] carry M, with the top bit as the MSB of M. Bits [4:0] carry S. For any M of 32 or more, the numeric value of the word therefore equals the period N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| reset_i | input | 1 | Synchronous reset, active high; restores the built-in ratio |
| sleep_i | input | 1 | Power-save, active high; stops counting and silences the output |
| load_i | input | 1 | Strobe that captures ratio_i as the pending ratio |
| ratio_i | input | 18 | Ratio word {M[12:0], S[4:0]} |
| pulse_o | output | 1 | One-cycle pulse at the end of every divided period |

## Verification
The bench measures pulse spacing at the edges of the ratio range, where off-by-one faults show up:
- S = 0 and S = 31 catch a swallow counter that stops one cycle early or late, because the period would miss by one.
- M = 32 catches a main counter that terminates at zero instead of one, because the period would grow by 32.
- A load in the middle of a period catches a design that reloads at once, because the current period would come out short or long.
- A double load catches a design that keeps the first value instead of the last.
- The sleep and reset tests count cycles from release, which catches a design that keeps a stale prescaler phase or forgets a ratio loaded while asleep.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;
    localparam int MAIN_W   = 13;
    localparam int SWAL_W   = 5;
    localparam int MAIN_MIN = 32;
    localparam int DEF_MAIN = 324;
    localparam int DEF_SWAL = 4;
endpackage

// File: rtl/sdiv_ratio_hold.sv
`timescale 1ns/1ps
module sdiv_ratio_hold #(
    parameter int MAIN_W   = 13,
    parameter int SWAL_W   = 5,
    parameter int MAIN_MIN = 32,
    parameter int DEF_MAIN = 324,
    parameter int DEF_SWAL = 4
) (
    input  logic                     clk_i,
    input  logic                     reset_i,
    input  logic                     load_i,
    input  logic [MAIN_W+SWAL_W-1:0] ratio_i,
    output logic [MAIN_W-1:0]        main_nxt_o,
    output logic [SWAL_W-1:0]        swal_nxt_o
);
    localparam logic [MAIN_W-1:0] FLOOR = MAIN_W'(MAIN_MIN);

    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic [SWAL_W-1:0] swal;
    } hold_t;

    hold_t st_d, st_q;
    logic [MAIN_W-1:0] main_raw;

    always_comb begin
        main_raw = ratio_i[MAIN_W+SWAL_W-1:SWAL_W];
        st_d     = st_q;
        if (load_i) begin
            st_d.main = (main_raw < FLOOR) ? FLOOR : main_raw;
            st_d.swal = ratio_i[SWAL_W-1:0];
        end
        main_nxt_o = st_d.main;
        swal_nxt_o = st_d.swal;
    end

    always_ff @(posedge clk_i) begin
        if (reset_i) begin
            st_q.main <= MAIN_W'(DEF_MAIN);
            st_q.swal <= SWAL_W'(DEF_SWAL);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sdiv_prescale.sv
`timescale 1ns/1ps
module sdiv_prescale #(
    parameter int BASE_W = 5
) (
    input  logic            clk_i,
    input  logic            reset_i,
    input  logic            run_i,
    input  logic            restart_i,
    input  logic            extra_i,
    output logic            wrap_o,
    output logic [BASE_W:0] count_o
);
    localparam int CNT_W = BASE_W + 1;
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'((1 << BASE_W) - 1);
    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(1 << BASE_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim    = extra_i ? LIM_LONG : LIM_SHORT;
        wrap_o = run_i && (st_q.cnt == lim);
        st_d   = st_q;
        if (restart_i || wrap_o) begin
            st_d.cnt = '0;
        end else if (run_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        count_o = st_q.cnt;
    end

    always_ff @(posedge clk_i) begin
        if (reset_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sdiv_swallow_cnt.sv
`timescale 1ns/1ps
module sdiv_swallow_cnt #(
    parameter int SWAL_W    = 5,
    parameter int RESET_VAL = 4
) (
    input  logic              clk_i,
    input  logic              reset_i,
    input  logic              tick_i,
    input  logic              restart_i,
    input  logic [SWAL_W-1:0] load_val_i,
    output logic              busy_o,
    output logic [SWAL_W-1:0] count_o
);
    typedef struct packed {
        logic [SWAL_W-1:0] cnt;
    } swal_t;

    swal_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.cnt = load_val_i;
        end else if (tick_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        busy_o  = (st_q.cnt != '0);
        count_o = st_q.cnt;
    end

    always_ff @(posedge clk_i) begin
        if (reset_i) begin
            st_q.cnt <= SWAL_W'(RESET_VAL);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sdiv_main_cnt.sv
`timescale 1ns/1ps
module sdiv_main_cnt #(
    parameter int MAIN_W    = 13,
    parameter int RESET_VAL = 324
) (
    input  logic              clk_i,
    input  logic              reset_i,
    input  logic              tick_i,
    input  logic              restart_i,
    input  logic [MAIN_W-1:0] load_val_i,
    output logic              term_o,
    output logic [MAIN_W-1:0] count_o
);
    typedef struct packed {
        logic [MAIN_W-1:0] cnt;
    } main_t;

    main_t st_d, st_q;

    always_comb begin
        term_o = tick_i && (st_q.cnt == MAIN_W'(1));
        st_d   = st_q;
        if (restart_i) begin
            st_d.cnt = load_val_i;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        count_o = st_q.cnt;
    end

    always_ff @(posedge clk_i) begin
        if (reset_i) begin
            st_q.cnt <= MAIN_W'(RESET_VAL);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/swallow_div.sv
`timescale 1ns/1ps
module swallow_div
    import sdiv_pkg::*;
#(
    parameter int P_MAIN_W   = MAIN_W,
    parameter int P_SWAL_W   = SWAL_W,
    parameter int P_MAIN_MIN = MAIN_MIN,
    parameter int P_DEF_MAIN = DEF_MAIN,
    parameter int P_DEF_SWAL = DEF_SWAL
) (
    input  logic                         clk_i,
    input  logic                         reset_i,
    input  logic                         sleep_i,
    input  logic                         load_i,
    input  logic [P_MAIN_W+P_SWAL_W-1:0] ratio_i,
    output logic                         pulse_o
);
    localparam int RATIO_W = P_MAIN_W + P_SWAL_W;

    typedef struct packed {
        logic pulse;
    } out_t;

    out_t st_d, st_q;

    logic [P_MAIN_W-1:0] main_nxt;
    logic [P_SWAL_W-1:0] swal_nxt;
    logic [P_SWAL_W:0]   pre_cnt;
    logic [P_SWAL_W-1:0] swal_cnt;
    logic [P_MAIN_W-1:0] main_cnt;
    logic                run;
    logic                restart;
    logic                wrap;
    logic                swal_busy;
    logic                term;

    sdiv_ratio_hold #(
        .MAIN_W  (P_MAIN_W),
        .SWAL_W  (P_SWAL_W),
        .MAIN_MIN(P_MAIN_MIN),
        .DEF_MAIN(P_DEF_MAIN),
        .DEF_SWAL(P_DEF_SWAL)
    ) u_hold (
        .clk_i     (clk_i),
        .reset_i   (reset_i),
        .load_i    (load_i),
        .ratio_i   (ratio_i[RATIO_W-1:0]),
        .main_nxt_o(main_nxt),
        .swal_nxt_o(swal_nxt)
    );

    sdiv_prescale #(
        .BASE_W(P_SWAL_W)
    ) u_pre (
        .clk_i    (clk_i),
        .reset_i  (reset_i),
        .run_i    (run),
        .restart_i(restart),
        .extra_i  (swal_busy),
        .wrap_o   (wrap),
        .count_o  (pre_cnt)
    );

    sdiv_swallow_cnt #(
        .SWAL_W   (P_SWAL_W),
        .RESET_VAL(P_DEF_SWAL)
    ) u_swal (
        .clk_i     (clk_i),
        .reset_i   (reset_i),
        .tick_i    (wrap),
        .restart_i (restart),
        .load_val_i(swal_nxt),
        .busy_o    (swal_busy),
        .count_o   (swal_cnt)
    );

    sdiv_main_cnt #(
        .MAIN_W   (P_MAIN_W),
        .RESET_VAL(P_DEF_MAIN)
    ) u_main (
        .clk_i     (clk_i),
        .reset_i   (reset_i),
        .tick_i    (wrap),
        .restart_i (restart),
        .load_val_i(main_nxt),
        .term_o    (term),
        .count_o   (main_cnt)
    );

    always_comb begin
        run      = !sleep_i;
        restart  = sleep_i || term;
        st_d     = st_q;
        st_d.pulse = term;
        pulse_o  = st_q.pulse;
    end

    always_ff @(posedge clk_i) begin
        if (reset_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sdiv_checks.sv
`timescale 1ns/1ps
module sdiv_checks #(
    parameter int P_MAIN_W = 13,
    parameter int P_SWAL_W = 5
) (
    input logic                clk_i,
    input logic                reset_i,
    input logic                sleep_i,
    input logic                pulse_o,
    input logic [P_SWAL_W:0]   pre_cnt,
    input logic [P_SWAL_W-1:0] swal_cnt,
    input logic [P_MAIN_W-1:0] main_cnt
);
    localparam logic [P_SWAL_W:0] LONG_TOP = (P_SWAL_W+1)'(1 << P_SWAL_W);

    // R3: prescaler never counts past the long modulus
    assert_pre_range_R3: assert property (@(posedge clk_i) disable iff (reset_i)
        pre_cnt <= LONG_TOP);

    // R3: the long modulus is only reached while swallowing
    assert_long_only_swallow_R3: assert property (@(posedge clk_i) disable iff (reset_i)
        (pre_cnt == LONG_TOP) |-> (swal_cnt != '0));

    // R2: main counter never wraps through zero
    assert_main_nonzero_R2: assert property (@(posedge clk_i) disable iff (reset_i)
        main_cnt != '0);

    // R4: output pulse lasts a single cycle
    assert_pulse_single_R4: assert property (@(posedge clk_i) disable iff (reset_i)
        pulse_o |=> !pulse_o);

    // R8: sleep silences the output and parks the prescaler
    assert_sleep_quiet_R8: assert property (@(posedge clk_i) disable iff (reset_i)
        sleep_i |=> (!pulse_o && pre_cnt == '0));
endmodule

bind swallow_div sdiv_checks #(
    .P_MAIN_W(P_MAIN_W),
    .P_SWAL_W(P_SWAL_W)
) u_chk (
    .clk_i   (clk_i),
    .reset_i (reset_i),
    .sleep_i (sleep_i),
    .pulse_o (pulse_o),
    .pre_cnt (pre_cnt),
    .swal_cnt(swal_cnt),
    .main_cnt(main_cnt)
);

// File: tb/tb_swallow_div.sv
`timescale 1ns/1ps
module tb_swallow_div;
    logic        clk_i = 1'b0;
    logic        reset_i;
    logic        sleep_i;
    logic        load_i;
    logic [17:0] ratio_i;
    logic        pulse_o;

    int tests  = 0;
    int failed = 0;
    bit done   = 1'b0;

    always #2.5 clk_i = ~clk_i;

    swallow_div dut (
        .clk_i  (clk_i),
        .reset_i(reset_i),
        .sleep_i(sleep_i),
        .load_i (load_i),
        .ratio_i(ratio_i),
        .pulse_o(pulse_o)
    );

    localparam int NV = 6;
    localparam logic [17:0] VEC_RATIO [NV] = '{
        {13'd32,  5'd0},
        {13'd32,  5'd31},
        {13'd33,  5'd1},
        {13'd100, 5'd0},
        {13'd40,  5'd17},
        {13'd57,  5'd31}
    };
    localparam int VEC_N [NV] = '{1024, 1055, 1057, 3200, 1297, 1855};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        forever begin
            @(negedge clk_i);
            load_i = 1'b0;
            n++;
            if (pulse_o) break;
            if (n > 12000) begin
                n = -1;
                break;
            end
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            failed++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        int n;
        int prev;
        int seen;
        reset_i = 1'b1;
        sleep_i = 1'b0;
        load_i  = 1'b0;
        ratio_i = '0;

        // R9: reset state, load during reset ignored
        repeat (2) @(negedge clk_i);
        load_i  = 1'b1;
        ratio_i = {13'd100, 5'd0};
        repeat (3) @(negedge clk_i);
        check(pulse_o == 1'b0, "R9 reset output", int'(pulse_o), 0);
        load_i  = 1'b0;
        reset_i = 1'b0;

        // R1: built-in ratio from release
        wait_pulse(n);
        check(n == 10372, "R1 first pulse", n, 10372);
        @(negedge clk_i);
        check(pulse_o == 1'b0, "R4 pulse width", int'(pulse_o), 0);
        wait_pulse(n);
        check(n == 10371, "R1 period", n + 1, 10372);

        // R2 R3 R5 R10: vector table, each load lands mid-period
        prev = 10372;
        for (int i = 0; i < NV; i++) begin
            load_i  = 1'b1;
            ratio_i = VEC_RATIO[i];
            wait_pulse(n);
            check(n == prev, "R5 period kept", n, prev);
            wait_pulse(n);
            check(n == VEC_N[i], "R2/R3 period", n, VEC_N[i]);
            check(n == int'(VEC_RATIO[i]), "R10 word equals N", n, int'(VEC_RATIO[i]));
            prev = VEC_N[i];
        end

        // R5: load 500 cycles into a period
        repeat (500) @(negedge clk_i);
        load_i  = 1'b1;
        ratio_i = 18'd1300;
        wait_pulse(n);
        check(n == 1355, "R5 late load", n, 1355);
        wait_pulse(n);
        check(n == 1300, "R10 numeric word", n, 1300);

        // R6: two loads in one period, last wins
        load_i  = 1'b1;
        ratio_i = {13'd100, 5'd0};
        @(negedge clk_i);
        ratio_i = {13'd32, 5'd7};
        @(negedge clk_i);
        load_i = 1'b0;
        wait_pulse(n);
        check(n == 1298, "R6 current period", n + 2, 1300);
        wait_pulse(n);
        check(n == 1031, "R6 last load", n, 1031);

        // R7: main count below floor
        load_i  = 1'b1;
        ratio_i = {13'd5, 5'd3};
        wait_pulse(n);
        wait_pulse(n);
        check(n == 1027, "R7 floor", n, 1027);

        // R8: sleep with a load inside it
        sleep_i = 1'b1;
        seen = 0;
        for (int k = 0; k < 1500; k++) begin
            @(negedge clk_i);
            load_i = (k == 10);
            if (k == 10) ratio_i = {13'd34, 5'd9};
            if (pulse_o) seen++;
        end
        check(seen == 0, "R8 no pulse asleep", seen, 0);
        load_i  = 1'b0;
        sleep_i = 1'b0;
        wait_pulse(n);
        check(n == 1097, "R8 after wake", n, 1097);

        // R9: reset mid-run restores built-in ratio
        repeat (300) @(negedge clk_i);
        reset_i = 1'b1;
        load_i  = 1'b1;
        ratio_i = {13'd32, 5'd0};
        repeat (3) @(negedge clk_i);
        check(pulse_o == 1'b0, "R9 held in reset", int'(pulse_o), 0);
        load_i  = 1'b0;
        reset_i = 1'b0;
        wait_pulse(n);
        check(n == 10372, "R9 default restored", n, 10372);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule